// File: doc/BRIEF.md
# Multi-Page-Size Translation Lookaside Buffer

This block is a fully associative, unified address-translation buffer. It holds a parameterised number of entries (64 by default). Each entry has a tag word, which is a virtual page number, and a data word. The data word carries the physical page number, a valid flag, a dirty flag, a 2-bit page-size code, a 2-bit access-rights code and a shareable flag. Each entry has its own page size, so each entry compares the incoming 32-bit virtual address under its own mask. When an entry matches, the block builds a 29-bit physical address. On a write access it also checks the access rights. A write that the rights forbid raises a protection fault. A first write to a clean page raises an initial-write fault.

Software loads entries through a load port: a strobe, an index, a tag word and a data word. A round-robin replacement counter is also provided. It advances on a step strobe and can be given an early wrap boundary, so that the top entries can be kept out of rotation. The counter value is an output, so it can drive the load index directly.

Top module: `tlb_lookup_unit`

## Requirements
- R1: An entry whose valid flag (data bit 0) is clear never produces a hit. Reset clears every entry, so every lookup after reset misses.
- R2: The page-size code in data bits 3:2 selects the compare mask as follows: 0 is 1 KB (mask 0xFFFFFC00), 1 is 4 KB (0xFFFFF000), 2 is 64 KB (0xFFFF0000) and 3 is 1 MB (0xFFF00000).
- R3: An entry matches when its tag word equals the virtual address in every bit that its mask keeps. Tag bits and address bits below the mask are ignored.
- R4: On a hit, the physical address takes the address bits outside the mask and the data-word bits inside the mask, and keeps only the low 29 bits. The shareable flag (data bit 6) of the entry that hit is returned alongside.
- R5: On a miss, the response shows hit low, physical address 0, fault code 0 and shareable 0.
- R6: The fault codes are 0 for none, 1 for protection and 2 for initial write. With access-rights code 1 or 3 (data bits 5:4), a write to an entry whose dirty flag (data bit 1) is clear returns code 2. Reads, and writes to dirty entries, return code 0.
- R7: With access-rights code 0 or 2, a write returns fault code 1 and a read returns code 0.
- R8: When several valid entries match, the entry with the lowest index supplies the result.
- R9: The response for a lookup request appears, with the response-valid flag high, in the cycle after the request. While no request is made, the response outputs keep their last values.
- R10: The replacement counter resets to 0. It advances by one on each cycle with the step strobe high, holds while the strobe is low, and returns to 0 when the advanced value would reach the entry count.
- R11: When the boundary input is nonzero, the counter returns to 0 in place of advancing to a value equal to the boundary.
- R12: A load strobe writes the tag and data words into the indexed entry. A lookup made in the same cycle as a load sees the contents from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Lookup is for a write access |
| ld_en | input | 1 | Entry load strobe |
| ld_idx | input | 6 | Index of the entry to load |
| ld_tag | input | 32 | Tag word to load |
| ld_data | input | 32 | Data word to load |
| rc_step | input | 1 | Replacement counter step |
| rc_bound | input | 6 | Early wrap boundary, 0 disables it |
| rc_value | output | 6 | Replacement counter value |
| rsp_valid | output | 1 | Response corresponds to a request made in the previous cycle |
| rsp_hit | output | 1 | Translation hit |
| rsp_pa | output | 29 | Physical address |
| rsp_fault | output | 2 | Fault code |
| rsp_shared | output | 1 | Shareable flag of the entry that hit |

## Verification
Translation is exercised with one entry of each page size. For each entry, the bench probes one address that differs only in the top offset bit and another that differs in the lowest page-number bit. Together these show whether each size code applies its own mask, or whether a mask is wider or narrower than it should be. Tag and data words with junk in their offset bits, and data bits above bit 28, show whether the address is assembled from the correct side of the mask. Overlapping entries show whether the lowest index wins, and invalid entries show whether the valid flag is honoured. Reads and writes against every access-rights code, with clean and dirty pages, separate the two fault kinds from each other and from a clean result. Full-range and bounded counter runs separate the natural wrap from the early wrap.

// File: rtl/tlb_pkg.sv
// Shared constants, field positions and helpers for the translation buffer.
// Assumes 32-bit virtual addresses, and flags packed below bit 10 of the data word.
package tlb_pkg;
    localparam int VA_W = 32;
    localparam int PA_W = 29;

    // Data word flag positions (page-number bits sit above bit 9)
    localparam int FLD_VALID = 0;
    localparam int FLD_DIRTY = 1;
    localparam int FLD_SZ    = 2;   // 2 bits
    localparam int FLD_PR    = 4;   // 2 bits
    localparam int FLD_SHARE = 6;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_PROT    = 2'd1,
        FLT_INIT_WR = 2'd2
    } fault_e;

    // Compare mask for a page-size code
    function automatic logic [VA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 32'hFFFF_FC00;
            2'd1:    size_mask = 32'hFFFF_F000;
            2'd2:    size_mask = 32'hFFFF_0000;
            default: size_mask = 32'hFFF0_0000;
        endcase
    endfunction
endpackage

// File: rtl/tlb_entry_array.sv
// Entry storage: one register pair (tag, data) per entry, written by the load port.
// Assumes one load per cycle; reads are combinational views of the registers.
module tlb_entry_array #(
    parameter int N_ENTRIES = 64,
    parameter int W         = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_en,
    input  logic [IDX_W-1:0]          ld_idx,
    input  logic [W-1:0]              ld_tag,
    input  logic [W-1:0]              ld_data,
    output logic [N_ENTRIES-1:0][W-1:0] tag_q,
    output logic [N_ENTRIES-1:0][W-1:0] data_q
);
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        // Clear entry on reset, capture load words when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (ld_en && ld_idx == IDX_W'(g)) begin
                tag_q[g]  <= ld_tag;
                data_q[g] <= ld_data;
            end
        end
    end

    p_load_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (tag_q[$past(ld_idx)] == $past(ld_tag)) &&
                  (data_q[$past(ld_idx)] == $past(ld_data)));
endmodule

// File: rtl/tlb_match.sv
// Parallel compare of the address against every entry under that entry's own
// page-size mask, followed by a lowest-index-first priority pick.
// Assumes flag layout from tlb_pkg; invalid entries are excluded.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [VA_W-1:0]              va,
    input  logic [N_ENTRIES-1:0][VA_W-1:0] tag_q,
    input  logic [N_ENTRIES-1:0][VA_W-1:0] data_q,
    output logic                         any_hit,
    output logic [IDX_W-1:0]             sel_idx
);
    logic [N_ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        // Per-entry masked equality, gated by the valid flag
        assign hit_vec[g] = data_q[g][FLD_VALID] &&
            (((tag_q[g] ^ va) & size_mask(data_q[g][FLD_SZ +: 2])) == '0);
    end

    // Lowest matching index wins
    always_comb begin
        any_hit = 1'b0;
        sel_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    p_hit_is_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> data_q[sel_idx][FLD_VALID]);
endmodule

// File: rtl/tlb_repl_ctr.sv
// Replacement counter: steps on request, wraps at the entry count or at a
// nonzero boundary, whichever the advanced value reaches.
// Assumes the boundary is static while stepping.
module tlb_repl_ctr #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] bound,
    output logic [IDX_W-1:0] cnt
);
    localparam logic [IDX_W:0] N_EXT = (IDX_W + 1)'(N_ENTRIES);

    logic [IDX_W:0] nxt;
    logic           wrap;

    // Advanced value and wrap decision
    always_comb begin
        nxt  = {1'b0, cnt} + 1'b1;
        wrap = (nxt >= N_EXT) || ((bound != '0) && (nxt == {1'b0, bound}));
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (step)  cnt <= wrap ? '0 : nxt[IDX_W-1:0];
    end

    p_ctr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));
    p_ctr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt == '0) || (cnt == IDX_W'($past(cnt) + 1'b1)));
    p_ctr_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && bound != '0 && IDX_W'(cnt + 1'b1) == bound) |=> cnt == '0);
endmodule

// File: rtl/tlb_lookup_unit.sv
// Top of the translation buffer: entry storage, parallel match, address
// assembly, rights check and registered response, plus the replacement counter.
// Assumes one lookup per cycle; a load in the same cycle is seen afterwards.
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [31:0]      lk_va,
    input  logic             lk_write,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [31:0]      ld_tag,
    input  logic [31:0]      ld_data,
    input  logic             rc_step,
    input  logic [IDX_W-1:0] rc_bound,
    output logic [IDX_W-1:0] rc_value,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [1:0]       rsp_fault,
    output logic             rsp_shared
);
    logic [N_ENTRIES-1:0][VA_W-1:0] tag_q;
    logic [N_ENTRIES-1:0][VA_W-1:0] data_q;
    logic                           any_hit;
    logic [IDX_W-1:0]               sel_idx;
    logic [VA_W-1:0]                sel_data;
    logic [VA_W-1:0]                sel_mask;
    logic [PA_W-1:0]                pa_c;
    fault_e                         flt_c;

    tlb_entry_array #(.N_ENTRIES(N_ENTRIES), .W(VA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_data(ld_data),
        .tag_q(tag_q), .data_q(data_q)
    );

    tlb_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .clk(clk), .rst_n(rst_n), .va(lk_va),
        .tag_q(tag_q), .data_q(data_q),
        .any_hit(any_hit), .sel_idx(sel_idx)
    );

    tlb_repl_ctr #(.N_ENTRIES(N_ENTRIES)) u_ctr (
        .clk(clk), .rst_n(rst_n), .step(rc_step), .bound(rc_bound), .cnt(rc_value)
    );

    // Assemble physical address from the selected entry
    always_comb begin
        sel_data = data_q[sel_idx];
        sel_mask = size_mask(sel_data[FLD_SZ +: 2]);
        pa_c     = PA_W'((lk_va & ~sel_mask) | (sel_data & sel_mask));
    end

    // Access-rights check: read-only codes fault on write, writable codes
    // fault on the first write to a clean page
    always_comb begin
        flt_c = FLT_NONE;
        if (lk_write) begin
            if (!sel_data[FLD_PR])           flt_c = FLT_PROT;
            else if (!sel_data[FLD_DIRTY])   flt_c = FLT_INIT_WR;
        end
    end

    // Registered response, held between requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_pa     <= '0;
            rsp_fault  <= FLT_NONE;
            rsp_shared <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) begin
                rsp_hit    <= any_hit;
                rsp_pa     <= any_hit ? pa_c : '0;
                rsp_fault  <= any_hit ? flt_c : FLT_NONE;
                rsp_shared <= any_hit & sel_data[FLD_SHARE];
            end
        end
    end

    p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_fault == 2'd0 && !rsp_shared));
    p_fault_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> $past(lk_write));
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> ($stable(rsp_pa) && $stable(rsp_hit) && $stable(rsp_fault)));
    p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'd3);
endmodule

// File: tb/tlb_lookup_unit_bench.sv
// Directed bench for the translation buffer.
module tlb_lookup_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_write = 1'b0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_idx = '0;
    logic [31:0] ld_tag = '0;
    logic [31:0] ld_data = '0;
    logic        rc_step = 1'b0;
    logic [5:0]  rc_bound = '0;
    logic [5:0]  rc_value;
    logic        rsp_valid, rsp_hit, rsp_shared;
    logic [28:0] rsp_pa;
    logic [1:0]  rsp_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tlb_lookup_unit u_tlb_lookup_unit (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_write(lk_write),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_data(ld_data),
        .rc_step(rc_step), .rc_bound(rc_bound), .rc_value(rc_value),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_shared(rsp_shared)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        case (sz)
            2'd0: return 32'hFFFF_FC00;
            2'd1: return 32'hFFFF_F000;
            2'd2: return 32'hFFFF_0000;
            default: return 32'hFFF0_0000;
        endcase
    endfunction

    function automatic logic [31:0] mkd(input logic [31:0] ppn, input bit v, input bit d,
                                        input logic [1:0] sz, input logic [1:0] pr, input bit sh);
        return ppn | 32'(sh) << 6 | 32'(pr) << 4 | 32'(sz) << 2 | 32'(d) << 1 | 32'(v);
    endfunction

    function automatic logic [31:0] xpa(input logic [31:0] va, input logic [31:0] dw);
        logic [31:0] m = mask_of(dw[3:2]);
        return ((va & ~m) | (dw & m)) & 32'h1FFF_FFFF;
    endfunction

    task automatic load(input int idx, input logic [31:0] tag, input logic [31:0] dw);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 6'(idx); ld_tag = tag; ld_data = dw;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] va, input bit wr,
                        input bit eh, input logic [31:0] epa, input logic [1:0] ef);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_write = wr;
        @(negedge clk);
        lk_req = 1'b0; lk_write = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " hit"},   32'(rsp_hit), 32'(eh));
        check({req, " pa"},    32'(rsp_pa), eh ? epa : 32'd0);
        check({req, " fault"}, 32'(rsp_fault), 32'(ef));
    endtask

    task automatic steps(input int n);
        @(negedge clk);
        rc_step = 1'b1;
        repeat (n) @(negedge clk);
        rc_step = 1'b0;
    endtask

    // Reset state and empty-buffer miss
    task automatic t_reset();
        check("R10 reset counter", 32'(rc_value), 32'd0);
        check("R9 reset valid", 32'(rsp_valid), 32'd0);
        look("R1 empty miss", 32'h1234_5678, 1'b0, 1'b0, 0, 2'd0);
    endtask

    // Each page size, inside/outside its mask, PA assembly
    task automatic t_sizes();
        logic [31:0] d0 = mkd(32'hEABC_D800, 1, 1, 2'd0, 2'd3, 1);
        logic [31:0] d1 = mkd(32'hF234_5000, 1, 1, 2'd1, 2'd3, 0);
        logic [31:0] d2 = mkd(32'h0777_0000, 1, 1, 2'd2, 2'd3, 0);
        logic [31:0] d3 = mkd(32'h1A50_0000, 1, 1, 2'd3, 2'd3, 0);
        load(0,  32'h1234_57AB, d0);
        load(5,  32'h4000_0FFF, d1);
        load(10, 32'h8001_1234, d2);
        load(20, 32'hC000_0000, d3);
        look("R2 R4 1K top offset", 32'h1234_57FF, 0, 1, xpa(32'h1234_57FF, d0), 0);
        check("R4 shareable", 32'(rsp_shared), 32'd1);
        look("R3 1K page bit", 32'h1234_5000, 0, 0, 0, 0);
        check("R5 miss shareable", 32'(rsp_shared), 32'd0);
        look("R2 R4 4K top offset", 32'h4000_0800, 0, 1, xpa(32'h4000_0800, d1), 0);
        look("R3 4K page bit", 32'h4000_1000, 0, 0, 0, 0);
        look("R2 R4 64K top offset", 32'h8001_8ABC, 0, 1, xpa(32'h8001_8ABC, d2), 0);
        look("R3 64K page bit", 32'h8000_0000, 0, 0, 0, 0);
        look("R2 R4 1M top offset", 32'hC008_1234, 0, 1, xpa(32'hC008_1234, d3), 0);
        look("R3 1M page bit", 32'hC010_0000, 0, 0, 0, 0);
    endtask

    // Valid flag and priority among overlapping entries
    task automatic t_valid_prio();
        load(30, 32'h5000_0000, mkd(32'h0100_0000, 0, 1, 2'd3, 2'd3, 0));
        look("R1 invalid entry", 32'h5000_0100, 0, 0, 0, 0);
        load(41, 32'h6000_0000, mkd(32'h0220_0000, 1, 1, 2'd3, 2'd3, 0));
        load(40, 32'h6000_0000, mkd(32'h0330_0000, 1, 1, 2'd3, 2'd3, 0));
        look("R8 lowest index", 32'h6000_0040, 0, 1, 32'h0330_0040, 0);
    endtask

    // Rights codes with clean/dirty pages, reads and writes
    task automatic t_rights();
        load(60, 32'h0010_0000, mkd(32'h0010_0000, 1, 0, 2'd3, 2'd3, 0));
        load(61, 32'h0020_0000, mkd(32'h0020_0000, 1, 1, 2'd3, 2'd1, 0));
        load(62, 32'h0030_0000, mkd(32'h0030_0000, 1, 1, 2'd3, 2'd0, 0));
        load(63, 32'h0040_0000, mkd(32'h0040_0000, 1, 0, 2'd3, 2'd2, 0));
        load(59, 32'h0050_0000, mkd(32'h0050_0000, 1, 0, 2'd3, 2'd1, 0));
        look("R6 write clean code3", 32'h0010_0004, 1, 1, 32'h0010_0004, 2'd2);
        look("R6 write clean code1", 32'h0050_0004, 1, 1, 32'h0050_0004, 2'd2);
        look("R6 read clean code3", 32'h0010_0004, 0, 1, 32'h0010_0004, 2'd0);
        look("R6 write dirty code1", 32'h0020_0008, 1, 1, 32'h0020_0008, 2'd0);
        look("R7 write code0", 32'h0030_000C, 1, 1, 32'h0030_000C, 2'd1);
        look("R7 write code2", 32'h0040_0010, 1, 1, 32'h0040_0010, 2'd1);
        look("R7 read code2", 32'h0040_0010, 0, 1, 32'h0040_0010, 2'd0);
        look("R5 write miss", 32'h0900_0000, 1, 0, 0, 2'd0);
    endtask

    // Load and lookup in the same cycle; idle hold
    task automatic t_load_collide();
        look("R9 prime", 32'h4000_0123, 0, 1, 32'h1234_5123, 0);
        @(negedge clk);
        @(negedge clk);
        check("R9 idle valid low", 32'(rsp_valid), 32'd0);
        check("R9 idle pa held", 32'(rsp_pa), 32'h1234_5123);
        check("R9 idle hit held", 32'(rsp_hit), 32'd1);
        @(negedge clk);
        ld_en = 1; ld_idx = 6'd50; ld_tag = 32'h7000_0000;
        ld_data = mkd(32'h0770_0000, 1, 1, 2'd3, 2'd3, 0);
        lk_req = 1; lk_va = 32'h7000_0010; lk_write = 0;
        @(negedge clk);
        ld_en = 0; lk_req = 0;
        check("R12 same-cycle old view", 32'(rsp_hit), 32'd0);
        look("R12 loaded entry", 32'h7000_0010, 0, 1, 32'h0770_0010, 0);
    endtask

    // Counter natural wrap, hold, and boundary wrap
    task automatic t_counter();
        steps(63);
        check("R10 count to 63", 32'(rc_value), 32'd63);
        steps(1);
        check("R10 wrap at count", 32'(rc_value), 32'd0);
        repeat (3) @(negedge clk);
        check("R10 hold", 32'(rc_value), 32'd0);
        rc_bound = 6'd5;
        steps(4);
        check("R11 below bound", 32'(rc_value), 32'd4);
        steps(1);
        check("R11 wrap at bound", 32'(rc_value), 32'd0);
        steps(2);
        check("R11 after bound wrap", 32'(rc_value), 32'd2);
        rc_bound = 6'd0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sizes();
        t_valid_prio();
        t_rights();
        t_load_collide();
        t_counter();
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end
endmodule